// File: doc/BRIEF.md
# PWM Time Base with Double-Buffered Period and Compare Registers

This block is the timing heart of a pulse-width modulator channel. A 16-bit counter advances on an enable that a two-stage prescaler derives from the module clock. It can count up, down, or up-down. The counter is compared against an active period value and four active compare thresholds, A to D. Single-cycle strobes report zero, period, and every compare match, with the count direction at the moment of the match.

Each of the five threshold registers has a buffer copy and an active copy. A register write port fills the buffer. Depending on a per-register select, the write either reaches the active copy at once or waits for a transfer event. For the period, the transfer event can be counter zero, counter zero once a sync pulse has been seen, or the sync pulse alone. Compares transfer at counter zero. Control software can therefore change duty or frequency at any time without producing a truncated or runt pulse.

Top module: `pwm_timebase`

## Requirements
- R1: The counter advances once every H*C clocks, where H is 1 when `hs_div` is 0 and 2*`hs_div` otherwise, and C is 2 to the power `ck_div`. The first advance happens at the H*C-th clock after reset is released.
- R2: After reset the count is 0, `dir_dn_o` is 0 and no strobe is high. With `cnt_mode`=0 (up), each advance increments the count. Once the count has reached or passed the active period, the next advance returns it to 0. `dir_dn_o` is 0 in this mode.
- R3: With `cnt_mode`=1 (down), each advance decrements the count. From 0, an advance loads the active period. `dir_dn_o` becomes 1 at the first advance.
- R4: With `cnt_mode`=2 (up-down), counting up reverses to down at or above the active period, and counting down reverses to up at 0. The reversing advance already moves one step in the new direction, and `dir_dn_o` follows the direction of that step.
- R5: With `cnt_mode`=3, the count and the direction hold their values.
- R6: `ev_zero_o` and `ev_prd_o` are high only in the first clock in which the count shows a newly advanced value equal to 0 or to the active period, respectively. Each strobe therefore lasts one clock per advance.
- R7: Bit i of `ev_cmp_up_o` (while `dir_dn_o`=0) or of `ev_cmp_dn_o` (while `dir_dn_o`=1) strobes under the same timing as R6 when the count equals active compare i. Index 0 is A and index 3 is D.
- R8: With `prd_direct`=1, a period write reaches the active period at the next clock edge.
- R9: With `prd_direct`=0 and `prd_load_sel` equal to 0 or 3, the buffered period becomes active at the clock edge that ends a clock where `ev_zero_o` is high, and at no other time.
- R10: With `prd_direct`=0 and `prd_load_sel`=1, a `sync_in` pulse is remembered. The transfer occurs at the next zero strobe, or at a zero strobe that coincides with the sync pulse, and the memory is then cleared. A zero strobe without a sync pulse transfers nothing.
- R11: With `prd_direct`=0 and `prd_load_sel`=2, the transfer occurs at the clock edge where `sync_in` is high, and at no other time.
- R12: Bit i of `cmp_direct` selects, for compare i, either an immediate write (1) or a transfer at the zero strobe (0).
- R13: When a write and a transfer of the same register fall in the same clock, the active copy receives the buffer contents from before that write. The new value waits for the next transfer.
- R14: Write address 0 selects the period and addresses 1 to 4 select compares A to D. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_mode | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| hs_div | input | 3 | First prescale stage select |
| ck_div | input | 3 | Second prescale stage select (power of two) |
| prd_direct | input | 1 | Period writes go straight to the active copy |
| prd_load_sel | input | 2 | Period transfer event: 0/3 zero, 1 zero after sync, 2 sync |
| cmp_direct | input | 4 | Per-compare direct write select |
| sync_in | input | 1 | Sync pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cnt_o | output | 16 | Counter value |
| dir_dn_o | output | 1 | 1 while counting down |
| ev_zero_o | output | 1 | Zero strobe |
| ev_prd_o | output | 1 | Period strobe |
| ev_cmp_up_o | output | 4 | Compare match strobes while counting up |
| ev_cmp_dn_o | output | 4 | Compare match strobes while counting down |

## Verification
Two functions can fall in the same clock: a register write and the transfer that the zero strobe triggers. Likewise, a sync pulse can arrive in the very clock of the zero strobe that should consume it. The bench waits at a falling edge until it sees the zero strobe, and then drives a period write in that same clock. A behavioural model decides from the requirements which value becomes active. Every following period strobe and wrap point shows whether the design used the old buffer contents or the new write. In the sync modes, pulses before, between and at zero events are judged the same way, through the counter's wrap points.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  localparam int NUM_CMP  = 4;
  localparam int NUM_REGS = NUM_CMP + 1;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2,
    CM_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    PL_ZERO      = 2'd0,
    PL_ZERO_SYNC = 2'd1,
    PL_SYNC      = 2'd2,
    PL_ZERO_ALT  = 2'd3
  } prd_load_e;

  // Clocks per counter advance for the two prescale selects.
  function automatic int unsigned div_product(input int unsigned hs_sel,
                                              input int unsigned ck_sel);
    int unsigned h;
    h = (hs_sel == 0) ? 1 : 2 * hs_sel;
    return h << ck_sel;
  endfunction

endpackage

// File: rtl/pwm_tb_prescale.sv
module pwm_tb_prescale
  import pwm_tb_pkg::*;
#(
  parameter int HS_W = 3,
  parameter int CK_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HS_W-1:0] hs_div,
  input  logic [CK_W-1:0] ck_div,
  output logic            tick
);

  localparam int MAX_DIV = (((1 << HS_W) - 1) * 2) << ((1 << CK_W) - 1);
  localparam int PW      = $clog2(MAX_DIV + 1);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] div_last;

  assign div_last = PW'(div_product(int'(hs_div), int'(ck_div)) - 1);
  assign tick     = (pcnt >= div_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + PW'(1);
  end

  // R1: with a divide above one, two advances are never adjacent
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_last != '0 && $stable(hs_div) && $stable(ck_div)) |=> !tick);

endmodule

// File: rtl/pwm_tb_shadow_reg.sv
module pwm_tb_shadow_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         direct,
  input  logic         load,
  output logic [W-1:0] active
);

  logic [W-1:0] shd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd    <= '0;
      active <= '0;
    end else begin
      if (wr) shd <= wdata;
      if (direct) begin
        if (wr) active <= wdata;
      end else if (load) begin
        active <= shd;
      end
    end
  end

  // R8/R12: direct writes land at the next edge
  a_r8_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && wr) |=> active == $past(wdata));

  // R13: a transfer takes the buffer as it stood before any same-cycle write
  a_r13_prior_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && load) |=> active == $past(shd));

  // R12: buffered registers keep their active value between transfers
  a_r12_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && !load) |=> $stable(active));

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  cnt_mode_e                  mode,
  input  logic [W-1:0]               prd,
  input  logic [NUM_CMP-1:0][W-1:0]  cmp,
  output logic [W-1:0]               cnt,
  output logic                       dir_dn,
  output logic                       ev_zero,
  output logic                       ev_prd,
  output logic [NUM_CMP-1:0]         ev_cu,
  output logic [NUM_CMP-1:0]         ev_cd
);

  logic [W-1:0] cnt_n;
  logic         dn_n;
  logic         fresh;

  always_comb begin
    cnt_n = cnt;
    dn_n  = dir_dn;
    case (mode)
      CM_UP: begin
        dn_n  = 1'b0;
        cnt_n = (cnt >= prd) ? '0 : cnt + W'(1);
      end
      CM_DOWN: begin
        dn_n  = 1'b1;
        cnt_n = (cnt == '0) ? prd : cnt - W'(1);
      end
      CM_UPDOWN: begin
        if (!dir_dn) begin
          if (cnt >= prd) begin
            dn_n  = 1'b1;
            cnt_n = (cnt == '0) ? '0 : cnt - W'(1);
          end else begin
            cnt_n = cnt + W'(1);
          end
        end else begin
          if (cnt == '0) begin
            dn_n  = 1'b0;
            cnt_n = (prd == '0) ? '0 : W'(1);
          end else begin
            cnt_n = cnt - W'(1);
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_dn <= 1'b0;
      fresh  <= 1'b0;
    end else begin
      fresh <= tick;
      if (tick) begin
        cnt    <= cnt_n;
        dir_dn <= dn_n;
      end
    end
  end

  assign ev_zero = fresh && (cnt == '0);
  assign ev_prd  = fresh && (cnt == prd);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign ev_cu[i] = fresh && !dir_dn && (cnt == cmp[i]);
    assign ev_cd[i] = fresh &&  dir_dn && (cnt == cmp[i]);
  end

  // R1: no advance without a prescaled tick
  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt) && $stable(dir_dn)));

  // R2: up mode wraps to zero at the period
  a_r2_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_UP && cnt >= prd) |=> cnt == '0);

  // R4: up-down turns at the period
  a_r4_turn_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == CM_UPDOWN && !dir_dn && cnt >= prd && cnt != '0) |=> dir_dn);

  // R5: hold mode keeps the count
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_HOLD) |=> $stable(cnt));

  // R6/R7: strobes only follow a tick
  a_r6_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (!ev_zero && !ev_prd && ev_cu == '0 && ev_cd == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int W    = 16,
  parameter int HS_W = 3,
  parameter int CK_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cnt_mode,
  input  logic [HS_W-1:0]     hs_div,
  input  logic [CK_W-1:0]     ck_div,
  input  logic                prd_direct,
  input  logic [1:0]          prd_load_sel,
  input  logic [NUM_CMP-1:0]  cmp_direct,
  input  logic                sync_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [W-1:0]        wr_data,
  output logic [W-1:0]        cnt_o,
  output logic                dir_dn_o,
  output logic                ev_zero_o,
  output logic                ev_prd_o,
  output logic [NUM_CMP-1:0]  ev_cmp_up_o,
  output logic [NUM_CMP-1:0]  ev_cmp_dn_o
);

  logic                        tick;
  logic                        ev_zero;
  logic                        prd_ld;
  logic                        sync_pend;
  logic [NUM_REGS-1:0]         wr_sel;
  logic [NUM_REGS-1:0]         reg_direct;
  logic [NUM_REGS-1:0]         reg_load;
  logic [NUM_REGS-1:0][W-1:0]  act_q;
  prd_load_e                   ld_sel;

  assign ld_sel = prd_load_e'(prd_load_sel);

  pwm_tb_prescale #(.HS_W(HS_W), .CK_W(CK_W)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_div (hs_div),
    .ck_div (ck_div),
    .tick   (tick)
  );

  // Write address decode: 0 period, 1..NUM_CMP compares.
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
  end

  // Period transfer event.
  always_comb begin
    case (ld_sel)
      PL_ZERO_SYNC: prd_ld = ev_zero && (sync_pend || sync_in);
      PL_SYNC:      prd_ld = sync_in;
      default:      prd_ld = ev_zero;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_pend <= 1'b0;
    else if (ld_sel == PL_ZERO_SYNC && !prd_direct)
      sync_pend <= (sync_pend || sync_in) && !prd_ld;
    else
      sync_pend <= 1'b0;
  end

  assign reg_direct = {cmp_direct, prd_direct};
  assign reg_load   = {{NUM_CMP{ev_zero}}, prd_ld};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    pwm_tb_shadow_reg #(.W(W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_sel[g]),
      .wdata  (wr_data),
      .direct (reg_direct[g]),
      .load   (reg_load[g]),
      .active (act_q[g])
    );
  end

  pwm_tb_counter #(.W(W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode    (cnt_mode_e'(cnt_mode)),
    .prd     (act_q[0]),
    .cmp     (act_q[NUM_REGS-1:1]),
    .cnt     (cnt_o),
    .dir_dn  (dir_dn_o),
    .ev_zero (ev_zero),
    .ev_prd  (ev_prd_o),
    .ev_cu   (ev_cmp_up_o),
    .ev_cd   (ev_cmp_dn_o)
  );

  assign ev_zero_o = ev_zero;

  // R9: zero-event modes leave the period alone away from zero strobes
  a_r9_zero_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_sel == PL_ZERO || ld_sel == PL_ZERO_ALT) && !prd_direct && !ev_zero)
      |=> $stable(act_q[0]));

  // R10: no transfer without a seen or coincident sync
  a_r10_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == PL_ZERO_SYNC && !prd_direct && !sync_pend && !sync_in)
      |=> $stable(act_q[0]));

  // R11: sync-only transfer
  a_r11_sync_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sel == PL_SYNC && !prd_direct && !sync_in) |=> $stable(act_q[0]));

  // R14: unused addresses select no register
  a_r14_no_stray_select: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_W'(NUM_CMP)) |-> wr_sel == '0);

endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cnt_mode = 2'd0;
  logic [2:0]    hs_div = 3'd0;
  logic [2:0]    ck_div = 3'd0;
  logic          prd_direct = 1'b1;
  logic [1:0]    prd_load_sel = 2'd0;
  logic [3:0]    cmp_direct = 4'hF;
  logic          sync_in = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = 3'd0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  cnt_o;
  logic          dir_dn_o, ev_zero_o, ev_prd_o;
  logic [3:0]    ev_cmp_up_o, ev_cmp_dn_o;

  always #5 clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .cnt_mode(cnt_mode), .hs_div(hs_div),
    .ck_div(ck_div), .prd_direct(prd_direct), .prd_load_sel(prd_load_sel),
    .cmp_direct(cmp_direct), .sync_in(sync_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cnt_o(cnt_o), .dir_dn_o(dir_dn_o),
    .ev_zero_o(ev_zero_o), .ev_prd_o(ev_prd_o), .ev_cmp_up_o(ev_cmp_up_o),
    .ev_cmp_dn_o(ev_cmp_dn_o)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string phase = "R2";

  // Behavioural reference state.
  int m_k, m_cnt, m_prd_a, m_prd_s;
  int m_ca[4];
  int m_cs[4];
  bit m_dn, m_fresh, m_pend;

  function automatic int clocks_per_step();
    int h;
    h = (hs_div == 0) ? 1 : 2 * int'(hs_div);
    return h * (1 << ck_div);
  endfunction

  function automatic logic [26:0] expected();
    logic [3:0] cu, cd;
    bit z, p;
    z = m_fresh && m_cnt == 0;
    p = m_fresh && m_cnt == m_prd_a;
    for (int i = 0; i < 4; i++) begin
      cu[i] = m_fresh && !m_dn && m_cnt == m_ca[i];
      cd[i] = m_fresh &&  m_dn && m_cnt == m_ca[i];
    end
    return {W'(m_cnt), m_dn, z, p, cu, cd};
  endfunction

  always @(posedge clk) begin : model
    bit tk, z, ld;
    int pa, old_s, n;
    int old_cs[4];
    if (!rst_n) begin
      m_k = 0; m_cnt = 0; m_prd_a = 0; m_prd_s = 0;
      m_dn = 0; m_fresh = 0; m_pend = 0;
      for (int i = 0; i < 4; i++) begin m_ca[i] = 0; m_cs[i] = 0; end
    end else begin
      n  = clocks_per_step();
      tk = (m_k % n) == (n - 1);
      z  = m_fresh && m_cnt == 0;
      pa = m_prd_a;
      case (prd_load_sel)
        2'd1:    ld = z && (m_pend || sync_in);
        2'd2:    ld = sync_in;
        default: ld = z;
      endcase
      // period register
      old_s = m_prd_s;
      if (wr_en && wr_addr == 0) begin
        m_prd_s = int'(wr_data);
        if (prd_direct) m_prd_a = int'(wr_data);
      end
      if (!prd_direct && ld) m_prd_a = old_s;
      if (prd_load_sel == 2'd1 && !prd_direct) m_pend = (m_pend || sync_in) && !ld;
      else m_pend = 0;
      // compare registers
      for (int i = 0; i < 4; i++) begin
        old_cs[i] = m_cs[i];
        if (wr_en && int'(wr_addr) == i + 1) begin
          m_cs[i] = int'(wr_data);
          if (cmp_direct[i]) m_ca[i] = int'(wr_data);
        end
        if (!cmp_direct[i] && z) m_ca[i] = old_cs[i];
      end
      // counter
      if (tk) begin
        if (cnt_mode == 2'd0) begin
          m_dn = 0;
          m_cnt = (m_cnt >= pa) ? 0 : m_cnt + 1;
        end else if (cnt_mode == 2'd1) begin
          m_dn = 1;
          m_cnt = (m_cnt == 0) ? pa : m_cnt - 1;
        end else if (cnt_mode == 2'd2) begin
          if (!m_dn && m_cnt >= pa) begin
            m_dn = 1; m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
          end else if (m_dn && m_cnt == 0) begin
            m_dn = 0; m_cnt = (pa > 0) ? 1 : 0;
          end else begin
            m_cnt = m_dn ? m_cnt - 1 : m_cnt + 1;
          end
        end
      end
      m_fresh = tk;
      m_k++;
    end
  end

  task automatic check(input string tag, input logic [26:0] act, input logic [26:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {cnt,dn,z,p,cu,cd} actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done)
      check(phase, {cnt_o, dir_dn_o, ev_zero_o, ev_prd_o, ev_cmp_up_o, ev_cmp_dn_o}, expected());
  end

  task automatic do_reset(input logic [1:0] mode, input logic [2:0] hs, input logic [2:0] ck);
    @(negedge clk);
    rst_n = 0;
    cnt_mode = mode; hs_div = hs; ck_div = ck;
    prd_direct = 1; prd_load_sel = 0; cmp_direct = 4'hF; sync_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    sync_in = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2", {cnt_o, dir_dn_o, ev_zero_o, ev_prd_o, ev_cmp_up_o, ev_cmp_dn_o}, '0);
    rst_n = 1;

    phase = "R8";
    wr(0, 5); wr(1, 2); wr(2, 5); wr(3, 0); wr(4, 9);
    phase = "R2"; run(20);
    phase = "R7"; run(12);

    phase = "R1";
    do_reset(2'd1, 3'd1, 3'd1);
    wr(0, 6); wr(1, 3);
    run(40);
    phase = "R3"; run(30);

    phase = "R4";
    do_reset(2'd2, 3'd0, 3'd0);
    wr(0, 4); wr(1, 4); wr(2, 0); wr(3, 2); wr(4, 1);
    run(30);
    phase = "R7"; run(20);
    phase = "R5"; cnt_mode = 2'd3; run(15);
    phase = "R4"; cnt_mode = 2'd2; run(10);

    phase = "R6";
    do_reset(2'd0, 3'd3, 3'd0);
    wr(0, 3); wr(1, 1);
    run(60);

    phase = "R9";
    do_reset(2'd0, 3'd0, 3'd0);
    wr(0, 9); wr(1, 4);
    prd_direct = 0; prd_load_sel = 2'd0;
    run(3); wr(0, 4); run(30);
    prd_load_sel = 2'd3; wr(0, 6); run(30);

    phase = "R10";
    prd_load_sel = 2'd1; wr(0, 3); run(25);
    sync_pulse(); run(25);
    wr(0, 7);
    @(negedge clk);
    while (!ev_zero_o) @(negedge clk);
    sync_in = 1;
    @(negedge clk);
    sync_in = 0;
    run(25);

    phase = "R11";
    prd_load_sel = 2'd2; wr(0, 8); run(20);
    sync_pulse(); run(30);

    phase = "R12";
    prd_load_sel = 2'd0;
    cmp_direct = 4'h0; wr(1, 3); run(30);
    cmp_direct = 4'b0010; wr(2, 5); wr(1, 6); run(30);

    phase = "R13";
    wr(0, 5); run(20);
    @(negedge clk);
    while (!ev_zero_o) @(negedge clk);
    wr_en = 1; wr_addr = 0; wr_data = 2;
    @(negedge clk);
    wr_en = 0;
    run(30);

    phase = "R14";
    cmp_direct = 4'hF; prd_direct = 1;
    wr(5, 1); wr(6, 2); wr(7, 3); run(20);

    phase = "R8";
    wr(0, 2); run(15);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule